// File: doc/BRIEF.md
# Hash Engine Scatter-Gather Front-End

This block is the register-driven control path in front of a hash core. Software programs a source pointer, a digest pointer, a key pointer, a total byte count and a command word through a small write/read register port. Writing the command word while the engine is idle launches a job. The block then reads memory through a request/grant read port with one outstanding request, and delivers the message one byte per beat on a valid/ready stream to the hash core. The hash arithmetic and the digest write-back belong to that core. The core pulses `core_done` once its digest is stored, which completes the job.

The engine has two modes. In direct mode, selected by command bit 18 clear, the source pointer names one contiguous word-aligned buffer of `len` bytes. In scatter-gather mode, selected by bit 18 set, the source pointer names an 8-byte-aligned list of descriptors. Each descriptor is a length word followed by an address word. Bit 31 of the length word flags the final segment, and bits 30:0 give its byte count. Segment addresses are word aligned, and each segment is a nonzero number of bytes.

The walker is a state machine with the states IDLE, LEN_REQ, LEN_RSP, PTR_REQ, PTR_RSP, DAT_REQ, DAT_RSP, EMIT and DIGEST. The transitions are:
- IDLE→LEN_REQ on a start in scatter-gather mode.
- IDLE→DAT_REQ on a start in direct mode with a nonzero length.
- IDLE→DIGEST on a start in direct mode with a zero length.
- Each *_REQ state moves to its *_RSP state on a grant.
- LEN_RSP→PTR_REQ on a response.
- PTR_RSP→DAT_REQ on a response. PTR_RSP instead goes to LEN_REQ or DIGEST when the segment is empty.
- DAT_RSP→EMIT on a response.
- EMIT stays in EMIT inside a word.
- EMIT→DAT_REQ at a word boundary.
- EMIT→LEN_REQ at the end of a segment that is not the final one.
- EMIT→DIGEST on the last beat.
- DIGEST→IDLE on `core_done`.

Top module: `hash_sg_frontend`

## Requirements
- R1: After reset, every register reads 0, and `hs_valid` and `mem_req` are low. While idle, neither `hs_valid` nor `mem_req` is asserted.
- R2: The register offsets are as follows. The status register is at 0x1C. Source is at 0x20, digest pointer at 0x24, key at 0x28, total length at 0x2C and command at 0x30. Each register reads back what was written, except that bits 2:0 of the digest pointer always read 0.
- R3: A write to 0x30 while idle starts a job. Status bit 0 (busy) reads 1 from the next cycle.
- R4: Direct mode streams `len` bytes from consecutive words starting at the source pointer. Bits 7:0 of each word go out first. The final byte carries `hs_last`.
- R5: Scatter-gather mode reads descriptor i at list base + 8·i, taking the length word first and the address word at +4. It streams the segments in list order. A memory request holds its address until it is granted.
- R6: A descriptor whose length word has bit 31 set ends the walk. Its last byte carries `hs_last`.
- R7: Without a bit-31 marker, the walk ends after 32 descriptors. Byte 32 of a list of 32 one-byte segments carries `hs_last`.
- R8: When the running byte count reaches the value of the total length register, streaming stops on that byte with `hs_last`, even in the middle of a segment.
- R9: After the last beat the engine stays busy until `core_done`. In that same cycle status bit 9 (done) sets and busy clears.
- R10: Writing status with bit 9 set clears the done flag. Writing status with bit 9 clear leaves it unchanged.
- R11: A command write while busy is ignored. The command register keeps its value and the running stream is unaffected.
- R12: The core configuration outputs follow the command register and the digest pointer. `core_algo` is command bits {10,6,5,4}, `core_be` is command bit 3, and `core_digest_addr` is the aligned digest pointer.
- R13: While `hs_valid` is high and `hs_ready` is low, `hs_valid`, `hs_data` and `hs_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_off | input | 8 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_off | input | 8 | Register read offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| hs_valid | output | 1 | Stream byte valid |
| hs_ready | input | 1 | Hash core accepts byte |
| hs_data | output | 8 | Stream byte |
| hs_last | output | 1 | Final byte of the message |
| core_algo | output | 4 | Algorithm code for the core |
| core_be | output | 1 | Big-endian digest select |
| core_digest_addr | output | 32 | Digest buffer pointer |
| core_done | input | 1 | Core finished digest write-back |

## Verification
A wrong descriptor index or segment counter shows up on the stream within a few beats. It appears as a byte whose value does not match its source address, or as `hs_last` on the wrong byte, because the memory model returns each byte's own address as its data. A stuck walker state keeps busy high after `core_done`, or lets the done flag rise early. The status read that follows each job catches either case one cycle after `core_done`. Errors in the register bank appear at the next read-back or on the core configuration outputs.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
    localparam logic [7:0] OFF_STATUS = 8'h1C;
    localparam logic [7:0] OFF_SRC    = 8'h20;
    localparam logic [7:0] OFF_DIGEST = 8'h24;
    localparam logic [7:0] OFF_KEY    = 8'h28;
    localparam logic [7:0] OFF_LEN    = 8'h2C;
    localparam logic [7:0] OFF_CMD    = 8'h30;
    localparam int BIT_BUSY = 0;
    localparam int BIT_DONE = 9;
    localparam int BIT_SG   = 18;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LEN_REQ, ST_LEN_RSP, ST_PTR_REQ, ST_PTR_RSP,
        ST_DAT_REQ, ST_DAT_RSP, ST_EMIT, ST_DIGEST
    } walk_state_e;
endpackage

// File: rtl/hsg_regs.sv
module hsg_regs
    import hsg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_off,
    input  logic [DW-1:0] wr_data,
    input  logic [7:0]    rd_off,
    output logic [DW-1:0] rd_data,
    input  logic          busy,
    input  logic          job_done,
    output logic          start,
    output logic [DW-1:0] src_q,
    output logic [DW-1:0] len_q,
    output logic [DW-1:0] cmd_q,
    output logic [DW-1:0] dig_q,
    output logic          done_flag
);
    logic [DW-1:0] key_q;

    assign start = wr_en && (wr_off == OFF_CMD) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q     <= '0;
            len_q     <= '0;
            cmd_q     <= '0;
            dig_q     <= '0;
            key_q     <= '0;
            done_flag <= 1'b0;
        end else begin
            if (wr_en) begin
                if (wr_off == OFF_SRC)    src_q <= wr_data;
                if (wr_off == OFF_LEN)    len_q <= wr_data;
                if (wr_off == OFF_KEY)    key_q <= wr_data;
                if (wr_off == OFF_DIGEST) dig_q <= {wr_data[DW-1:3], 3'b000};
            end
            if (start) cmd_q <= wr_data;
            if (job_done)
                done_flag <= 1'b1;
            else if (wr_en && (wr_off == OFF_STATUS) && wr_data[BIT_DONE])
                done_flag <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_off)
            OFF_STATUS: begin
                rd_data[BIT_BUSY] = busy;
                rd_data[BIT_DONE] = done_flag;
            end
            OFF_SRC:    rd_data = src_q;
            OFF_DIGEST: rd_data = dig_q;
            OFF_KEY:    rd_data = key_q;
            OFF_LEN:    rd_data = len_q;
            OFF_CMD:    rd_data = cmd_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/hsg_walker.sv
module hsg_walker
    import hsg_pkg::*;
#(
    parameter int DW       = 32,
    parameter int MAX_DESC = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sg_mode,
    input  logic [DW-1:0] list_base,
    input  logic [DW-1:0] total_len,
    output logic          busy,
    output logic          job_done,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          hs_valid,
    input  logic          hs_ready,
    output logic [7:0]    hs_data,
    output logic          hs_last,
    input  logic          core_done
);
    localparam int IDX_W = $clog2(MAX_DESC + 1);
    localparam int LEN_W = DW - 1;
    localparam int BPW   = DW / 8;
    localparam int SEL_W = $clog2(BPW);

    walk_state_e       state_q;
    logic [DW-1:0]     base_q, total_q, seg_addr_q, sent_q, word_q;
    logic [LEN_W-1:0]  seg_rem_q;
    logic              seg_final_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DW-1:0]     desc_addr;
    logic              seg_end;

    assign desc_addr = base_q + DW'({idx_q, 3'b000});
    assign seg_end   = (seg_rem_q == LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            base_q      <= '0;
            total_q     <= '0;
            seg_addr_q  <= '0;
            sent_q      <= '0;
            word_q      <= '0;
            seg_rem_q   <= '0;
            seg_final_q <= 1'b0;
            idx_q       <= '0;
            sel_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    base_q      <= {list_base[DW-1:3], 3'b000};
                    total_q     <= total_len;
                    idx_q       <= '0;
                    sent_q      <= '0;
                    seg_addr_q  <= list_base;
                    seg_rem_q   <= total_len[LEN_W-1:0];
                    seg_final_q <= 1'b1;
                    if (sg_mode)              state_q <= ST_LEN_REQ;
                    else if (total_len == '0) state_q <= ST_DIGEST;
                    else                      state_q <= ST_DAT_REQ;
                end
                ST_LEN_REQ: if (mem_gnt) state_q <= ST_LEN_RSP;
                ST_LEN_RSP: if (mem_rvalid) begin
                    seg_rem_q   <= mem_rdata[LEN_W-1:0];
                    seg_final_q <= mem_rdata[DW-1] || (idx_q == IDX_W'(MAX_DESC - 1));
                    state_q     <= ST_PTR_REQ;
                end
                ST_PTR_REQ: if (mem_gnt) state_q <= ST_PTR_RSP;
                ST_PTR_RSP: if (mem_rvalid) begin
                    seg_addr_q <= mem_rdata;
                    idx_q      <= idx_q + 1'b1;
                    if (seg_rem_q != '0)  state_q <= ST_DAT_REQ;
                    else if (seg_final_q) state_q <= ST_DIGEST;
                    else                  state_q <= ST_LEN_REQ;
                end
                ST_DAT_REQ: if (mem_gnt) state_q <= ST_DAT_RSP;
                ST_DAT_RSP: if (mem_rvalid) begin
                    word_q  <= mem_rdata;
                    sel_q   <= '0;
                    state_q <= ST_EMIT;
                end
                ST_EMIT: if (hs_ready) begin
                    sent_q    <= sent_q + 1'b1;
                    seg_rem_q <= seg_rem_q - 1'b1;
                    sel_q     <= sel_q + 1'b1;
                    if (hs_last)
                        state_q <= ST_DIGEST;
                    else if (seg_end)
                        state_q <= ST_LEN_REQ;
                    else if (sel_q == SEL_W'(BPW - 1)) begin
                        seg_addr_q <= seg_addr_q + DW'(BPW);
                        state_q    <= ST_DAT_REQ;
                    end
                end
                ST_DIGEST: if (core_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        job_done = (state_q == ST_DIGEST) && core_done;
        mem_req  = 1'b0;
        mem_addr = '0;
        hs_valid = (state_q == ST_EMIT);
        hs_data  = word_q[8*sel_q +: 8];
        hs_last  = hs_valid && (((sent_q + 1'b1) == total_q) || (seg_end && seg_final_q));
        unique case (state_q)
            ST_LEN_REQ: begin mem_req = 1'b1; mem_addr = desc_addr;            end
            ST_PTR_REQ: begin mem_req = 1'b1; mem_addr = desc_addr + DW'(4);   end
            ST_DAT_REQ: begin mem_req = 1'b1; mem_addr = seg_addr_q;           end
            default:    begin mem_req = 1'b0; mem_addr = '0;                   end
        endcase
    end
endmodule

// File: rtl/hash_sg_frontend.sv
module hash_sg_frontend
    import hsg_pkg::*;
#(
    parameter int DW       = 32,
    parameter int MAX_DESC = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [7:0]    reg_wr_off,
    input  logic [DW-1:0] reg_wr_data,
    input  logic [7:0]    reg_rd_off,
    output logic [DW-1:0] reg_rd_data,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          hs_valid,
    input  logic          hs_ready,
    output logic [7:0]    hs_data,
    output logic          hs_last,
    output logic [3:0]    core_algo,
    output logic          core_be,
    output logic [DW-1:0] core_digest_addr,
    input  logic          core_done
);
    logic          busy, job_done, start, done_flag;
    logic [DW-1:0] src_q, len_q, cmd_q, dig_q;
    logic          unused_cmd_bits;

    hsg_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_off(reg_wr_off), .wr_data(reg_wr_data),
        .rd_off(reg_rd_off), .rd_data(reg_rd_data),
        .busy(busy), .job_done(job_done), .start(start),
        .src_q(src_q), .len_q(len_q), .cmd_q(cmd_q), .dig_q(dig_q),
        .done_flag(done_flag)
    );

    hsg_walker #(.DW(DW), .MAX_DESC(MAX_DESC)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .start(start), .sg_mode(reg_wr_data[BIT_SG]),
        .list_base(src_q), .total_len(len_q),
        .busy(busy), .job_done(job_done),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .hs_valid(hs_valid), .hs_ready(hs_ready), .hs_data(hs_data),
        .hs_last(hs_last), .core_done(core_done)
    );

    assign core_algo        = {cmd_q[10], cmd_q[6], cmd_q[5], cmd_q[4]};
    assign core_be          = cmd_q[3];
    assign core_digest_addr = dig_q;
    assign unused_cmd_bits  = ^{cmd_q[DW-1:11], cmd_q[9:7], cmd_q[2:0]};
endmodule

// File: rtl/hsg_chk.sv
module hsg_chk
    import hsg_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr_en,
    input logic [7:0]    reg_wr_off,
    input logic          busy,
    input logic          done_flag,
    input logic [DW-1:0] cmd_q,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [DW-1:0] mem_addr,
    input logic          hs_valid,
    input logic          hs_ready,
    input logic [7:0]    hs_data,
    input logic          hs_last
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!hs_valid && !mem_req));

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_off == OFF_CMD && !busy) |=> busy);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (!busy && $past(busy)));

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr_en && reg_wr_off == OFF_CMD) |=> $stable(cmd_q));

    // R13
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && !hs_ready) |=> (hs_valid && $stable(hs_data) && $stable(hs_last)));
endmodule

bind hash_sg_frontend hsg_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_off(reg_wr_off),
    .busy(busy), .done_flag(done_flag), .cmd_q(cmd_q),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .hs_valid(hs_valid), .hs_ready(hs_ready), .hs_data(hs_data), .hs_last(hs_last)
);

// File: tb/sim_hash_sg_frontend.sv
`timescale 1ns/1ps
module sim_hash_sg_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_off = '0;
    logic [31:0] reg_wr_data = '0;
    logic [7:0]  reg_rd_off = '0;
    logic [31:0] reg_rd_data;
    logic        mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic        hs_valid, hs_ready = 1'b0, hs_last;
    logic [7:0]  hs_data;
    logic [3:0]  core_algo;
    logic        core_be, core_done = 1'b0;
    logic [31:0] core_digest_addr;

    int n_chk = 0;
    int n_fail = 0;
    logic [8:0]  exp_q[$];
    logic [31:0] mem [0:255];
    int cyc = 0;

    always #2.5 clk = ~clk;

    hash_sg_frontend u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_off = off; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_rd_off = off;
        #1 d = reg_rd_data;
    endtask

    task automatic push(input logic [7:0] b, input bit last);
        exp_q.push_back({last, b});
    endtask

    // finish a job: wait for the stream to drain, confirm busy holds, then complete
    task automatic finish_job(input string req);
        logic [31:0] s;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        rd(8'h1C, s);
        chk(s == 32'h1, {req, " R9 busy until core_done"}, s, 32'h1);
        @(negedge clk); core_done = 1'b1;
        @(negedge clk); core_done = 1'b0;
        rd(8'h1C, s);
        chk(s == 32'h200, {req, " R9 done set busy clear"}, s, 32'h200);
        wr(8'h1C, 32'h200);
    endtask

    // pacing of grant and ready
    initial forever begin
        @(posedge clk);
        cyc++;
        mem_gnt  <= (cyc % 2) == 0;
        hs_ready <= (cyc % 3) != 1;
    end

    // memory model: response one cycle after grant
    always @(posedge clk) begin
        mem_rvalid <= mem_req && mem_gnt;
        mem_rdata  <= mem[mem_addr[9:2]];
    end

    // scoreboard monitor
    logic       stall_prev = 1'b0;
    logic [8:0] stall_val = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev)
                chk(hs_valid && {hs_last, hs_data} == stall_val, "R13 hold under stall",
                    {23'd0, hs_last, hs_data}, {23'd0, stall_val});
            stall_prev = hs_valid && !hs_ready;
            stall_val  = {hs_last, hs_data};
            if (hs_valid && hs_ready) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R4-stream unexpected beat", {23'd0, hs_last, hs_data}, 32'h0);
                else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk({hs_last, hs_data} == e, "R4/R5/R6/R7/R8 stream byte",
                        {23'd0, hs_last, hs_data}, {23'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int k = 0; k < 256; k++)
            mem[k] = {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(8'h1C, v); chk(v == 0, "R1 status after reset", v, 0);
        rd(8'h30, v); chk(v == 0, "R1 cmd after reset", v, 0);
        chk(!hs_valid && !mem_req, "R1 outputs quiet", {30'd0, hs_valid, mem_req}, 0);
        rst_n = 1'b1;

        // R2 register map
        wr(8'h20, 32'h40);       rd(8'h20, v); chk(v == 32'h40, "R2 source readback", v, 32'h40);
        wr(8'h24, 32'h123);      rd(8'h24, v); chk(v == 32'h120, "R2 digest aligned", v, 32'h120);
        wr(8'h28, 32'hA5A5_0001); rd(8'h28, v); chk(v == 32'hA5A5_0001, "R2 key readback", v, 32'hA5A5_0001);
        wr(8'h2C, 32'd7);        rd(8'h2C, v); chk(v == 32'd7, "R2 length readback", v, 7);

        // direct job: R3 R4 R11 R12
        for (int i = 0; i < 7; i++) push(8'(8'h40 + i), i == 6);
        wr(8'h30, 32'h58);
        rd(8'h1C, v); chk(v[0] == 1'b1, "R3 busy after start", v, 1);
        wr(8'h30, 32'h20);
        rd(8'h30, v); chk(v == 32'h58, "R11 cmd ignored while busy", v, 32'h58);
        chk(core_algo == 4'b0101, "R12 algo code", {28'd0, core_algo}, 5);
        chk(core_be == 1'b1, "R12 endian select", {31'd0, core_be}, 1);
        chk(core_digest_addr == 32'h120, "R12 digest pointer", core_digest_addr, 32'h120);
        finish_job("direct");

        // R10 write-0 keeps, write-1 clears (flag re-raised by a zero-length direct job)
        wr(8'h2C, 32'd0);
        wr(8'h30, 32'h0);
        @(negedge clk); core_done = 1'b1;
        @(negedge clk); core_done = 1'b0;
        wr(8'h1C, 32'h0);
        rd(8'h1C, v); chk(v == 32'h200, "R10 write 0 keeps flag", v, 32'h200);
        wr(8'h1C, 32'h200);
        rd(8'h1C, v); chk(v == 32'h0, "R10 write 1 clears flag", v, 0);

        // R5 R6 scatter-gather with final marker
        mem[192] = 32'd5;         mem[193] = 32'h10;
        mem[194] = 32'h8000_0003; mem[195] = 32'h80;
        for (int i = 0; i < 5; i++) push(8'(8'h10 + i), 1'b0);
        for (int i = 0; i < 3; i++) push(8'(8'h80 + i), i == 2);
        wr(8'h20, 32'h300); wr(8'h2C, 32'd100);
        wr(8'h30, 32'h0004_0068);
        finish_job("R5 R6 sg");

        // R8 total length cuts the second segment
        mem[208] = 32'd6;         mem[209] = 32'h20;
        mem[210] = 32'h8000_0006; mem[211] = 32'h60;
        for (int i = 0; i < 6; i++) push(8'(8'h20 + i), 1'b0);
        push(8'h60, 1'b0); push(8'h61, 1'b1);
        wr(8'h20, 32'h340); wr(8'h2C, 32'd8);
        wr(8'h30, 32'h0004_0068);
        finish_job("R8 total");

        // R7 cap at 32 descriptors
        for (int i = 0; i < 32; i++) begin
            mem[192 + 2*i] = 32'd1;
            mem[193 + 2*i] = 32'(4*i);
            push(8'(4*i), i == 31);
        end
        wr(8'h20, 32'h300); wr(8'h2C, 32'd1000);
        wr(8'h30, 32'h0004_0028);
        finish_job("R7 cap");
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0 && !hs_valid, "R7 no beat after cap", {31'd0, hs_valid}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule